// File: doc/BRIEF.md
# Power-Down Mode Controller

This block holds one 8-bit control byte that software writes over a plain register port, and runs a three-state mode machine (run, sleep, standby) from it. A single sleep-request strobe enters either light sleep, where only the processor clock enable drops, or standby, where every clock enable drops. The choice depends on the standby-select bit of the control byte. In standby, output pins either keep their last value or float, as a second control bit selects.

Five module-stop bits each remove the clock enable of one peripheral. The stopped peripheral keeps its state and resumes from it when its bit clears. Two writes are refused because of the live state of neighbouring blocks: setting the standby-select bit while the watchdog runs, and stopping the DMA engine's clock while it is transferring. The rest of such a write still takes effect.

An interrupt or the non-maskable interrupt ends sleep. Only the non-maskable interrupt or reset ends standby. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `rd_data` is 0x00, `mode` is 00 (run), `cpu_clk_en` is 1, `mod_clk_en` is 5'b11111, `pin_oe` is 1 and `pin_hold` is 0.
- R2: A write with `wr_en` high loads the control byte on the next clock. The byte holds standby-select at bit 7, pin-float at bit 6, and module-stop bits at bits 4..0, where bit i stops module i. The stored byte is read back on `rd_data` at the same positions.
- R3: Bit 5 of `rd_data` always reads 0, whatever value is written to it.
- R4: While `wdt_running` is 1, a write cannot change bit 7 from 0 to 1, but it still updates every other bit. Clearing bit 7 is always accepted.
- R5: Outside standby, `mod_clk_en[i]` is the inverse of module-stop bit i.
- R6: While `dma_busy` is 1, a write cannot change bit 4 (the DMA module stop) from 0 to 1, but it still updates every other bit. Clearing bit 4 is always accepted.
- R7: In run mode, `sleep_req` with bit 7 = 0 gives `mode` = 01 on the next clock. In this mode `cpu_clk_en` is 0 and `mod_clk_en` is unchanged.
- R8: In run mode, `sleep_req` with bit 7 = 1 gives `mode` = 10 on the next clock. In this mode `cpu_clk_en` is 0 and `mod_clk_en` is 5'b00000.
- R9: From sleep, `irq_wake` or `nmi_wake` returns `mode` to 00 on the next clock. From standby, `irq_wake` has no effect and only `nmi_wake` returns `mode` to 00.
- R10: In standby, bit 6 = 0 gives `pin_hold` = 1 and `pin_oe` = 1, and bit 6 = 1 gives `pin_oe` = 0 and `pin_hold` = 0. Outside standby, `pin_oe` is 1 and `pin_hold` is 0.
- R11: `sleep_req` has no effect while `mode` is not 00.
- R12: Asserting `rst_n` low from any mode immediately forces the R1 output values, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Data written to the control byte |
| rd_data | output | 8 | Current control byte |
| sleep_req | input | 1 | Request to leave run mode |
| irq_wake | input | 1 | Enabled interrupt, ends sleep |
| nmi_wake | input | 1 | Non-maskable interrupt, ends sleep or standby |
| wdt_running | input | 1 | Watchdog timer is counting |
| dma_busy | input | 1 | DMA engine is transferring |
| cpu_clk_en | output | 1 | Processor clock enable |
| mod_clk_en | output | 5 | Per-module clock enables |
| pin_oe | output | 1 | Output-enable for controlled pins |
| pin_hold | output | 1 | Latch controlled pins at their last value |
| mode | output | 2 | 00 run, 01 sleep, 10 standby |

## Verification
The bench uses the default parameters: a two-stage reset-release synchroniser and the DMA interlock on module slot 4. With these, the interlock and its bit position can be seen at the ports. The release delay is short enough that a vector walk can start a few cycles after reset. Reset is also pulled low in the middle of standby, which exercises the asynchronous assertion path through the synchroniser.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int REG_W   = 8;
  localparam int MSTP_W  = 5;
  localparam int SBY_POS = 7;
  localparam int HIZ_POS = 6;
  localparam int RSV_POS = 5;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STBY  = 2'b10
  } pd_mode_e;

  typedef struct packed {
    logic              sby;
    logic              hiz;
    logic [MSTP_W-1:0] mstp;
  } pd_ctrl_t;
endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwrdn_reg.sv
module pwrdn_reg
  import pwrdn_pkg::*;
#(
  parameter int DMA_SLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wdt_running,
  input  logic             dma_busy,
  output pd_ctrl_t         ctrl,
  output logic [REG_W-1:0] rd_data
);
  pd_ctrl_t ctrl_q, ctrl_d;
  logic     sby_wr;
  logic [MSTP_W-1:0] mstp_wr;

  always_comb begin
    // refuse 0->1 on standby select while the watchdog counts
    sby_wr = wr_data[SBY_POS] & ~(wdt_running & ~ctrl_q.sby);
    mstp_wr = wr_data[MSTP_W-1:0];
    // refuse 0->1 on the DMA module stop while a transfer is active
    mstp_wr[DMA_SLOT] = wr_data[DMA_SLOT] & ~(dma_busy & ~ctrl_q.mstp[DMA_SLOT]);
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.sby  = sby_wr;
      ctrl_d.hiz  = wr_data[HIZ_POS];
      ctrl_d.mstp = mstp_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  assign rd_data = {ctrl_q.sby, ctrl_q.hiz, 1'b0, ctrl_q.mstp};
endmodule

// File: rtl/pwrdn_mode_fsm.sv
module pwrdn_mode_fsm
  import pwrdn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_req,
  input  logic     sby_sel,
  input  logic     irq_wake,
  input  logic     nmi_wake,
  output pd_mode_e mode
);
  pd_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:   if (sleep_req) mode_d = sby_sel ? MODE_STBY : MODE_SLEEP;
      MODE_SLEEP: if (irq_wake || nmi_wake) mode_d = MODE_RUN;
      MODE_STBY:  if (nmi_wake) mode_d = MODE_RUN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/pwrdn_enables.sv
module pwrdn_enables
  import pwrdn_pkg::*;
(
  input  pd_mode_e          mode,
  input  pd_ctrl_t          ctrl,
  output logic              cpu_clk_en,
  output logic [MSTP_W-1:0] mod_clk_en,
  output logic              pin_oe,
  output logic              pin_hold
);
  logic in_stby;
  assign in_stby    = (mode == MODE_STBY);
  assign cpu_clk_en = (mode == MODE_RUN);

  for (genvar g = 0; g < MSTP_W; g++) begin : g_mod_en
    assign mod_clk_en[g] = ~ctrl.mstp[g] & ~in_stby;
  end

  assign pin_oe   = ~(in_stby & ctrl.hiz);
  assign pin_hold = in_stby & ~ctrl.hiz;
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DMA_SLOT    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sleep_req,
  input  logic             irq_wake,
  input  logic             nmi_wake,
  input  logic             wdt_running,
  input  logic             dma_busy,
  output logic             cpu_clk_en,
  output logic [MSTP_W-1:0] mod_clk_en,
  output logic             pin_oe,
  output logic             pin_hold,
  output logic [1:0]       mode
);
  logic     rst_sync_n;
  pd_ctrl_t ctrl;
  pd_mode_e mode_e;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pwrdn_reg #(.DMA_SLOT(DMA_SLOT)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .wdt_running(wdt_running), .dma_busy(dma_busy),
    .ctrl(ctrl), .rd_data(rd_data));

  pwrdn_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .sleep_req(sleep_req), .sby_sel(ctrl.sby),
    .irq_wake(irq_wake), .nmi_wake(nmi_wake), .mode(mode_e));

  pwrdn_enables u_en (
    .mode(mode_e), .ctrl(ctrl), .cpu_clk_en(cpu_clk_en),
    .mod_clk_en(mod_clk_en), .pin_oe(pin_oe), .pin_hold(pin_hold));

  assign mode = mode_e;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int DMA_SLOT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       sleep_req,
  input logic       irq_wake,
  input logic       nmi_wake,
  input logic       wdt_running,
  input logic       dma_busy,
  input logic       cpu_clk_en,
  input logic [4:0] mod_clk_en,
  input logic       pin_oe,
  input logic       pin_hold,
  input logic [1:0] mode
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] == 1'b0);

  p_sby_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_running && !rd_data[7]) |=> !rd_data[7]);

  p_dma_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !rd_data[DMA_SLOT]) |=> !rd_data[DMA_SLOT]);

  p_sleep_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && sleep_req && !rd_data[7]) |=> mode == 2'b01);

  p_stby_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && sleep_req && rd_data[7]) |=> mode == 2'b10);

  p_stby_clocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> (!cpu_clk_en && mod_clk_en == 5'b0));

  p_stby_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !nmi_wake) |=> mode == 2'b10);

  p_sleep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && (irq_wake || nmi_wake)) |=> mode == 2'b00);

  p_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10 |-> (pin_oe && !pin_hold));

  p_no_reenter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !irq_wake && !nmi_wake) |=> mode == 2'b01);

  p_mode_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.DMA_SLOT(DMA_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_data(rd_data), .sleep_req(sleep_req),
  .irq_wake(irq_wake), .nmi_wake(nmi_wake), .wdt_running(wdt_running),
  .dma_busy(dma_busy), .cpu_clk_en(cpu_clk_en), .mod_clk_en(mod_clk_en),
  .pin_oe(pin_oe), .pin_hold(pin_hold), .mode(mode));

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  typedef struct packed {
    logic       wr;
    logic [7:0] d;
    logic       wdt;
    logic       dma;
    logic       slp;
    logic       irq;
    logic       nmi;
    logic [7:0] erd;
    logic [1:0] emode;
    logic       ecpu;
    logic [4:0] emod;
    logic       eoe;
    logic       ehold;
  } vec_t;

  // wr d wdt dma slp irq nmi | rd mode cpu mod oe hold
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hDF, 2'b00, 1'b1, 5'h00, 1'b1, 1'b0}, // R2 R3 R5
    '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R2
    '{1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R4
    '{1'b1, 8'hC5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h45, 2'b00, 1'b1, 5'h1A, 1'b1, 1'b0}, // R4 R5
    '{1'b1, 8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R6
    '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R4 clear
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 2'b00, 1'b1, 5'h0E, 1'b1, 1'b0}, // R5
    '{1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 2'b00, 1'b1, 5'h1E, 1'b1, 1'b0}, // R6 clear
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 2'b01, 1'b0, 5'h1E, 1'b1, 1'b0}, // R7
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 2'b01, 1'b0, 5'h1E, 1'b1, 1'b0}, // R11
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 2'b00, 1'b1, 5'h1E, 1'b1, 1'b0}, // R9
    '{1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R2
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 2'b10, 1'b0, 5'h00, 1'b1, 1'b1}, // R8 R10
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 2'b10, 1'b0, 5'h00, 1'b1, 1'b1}, // R9
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 2'b10, 1'b0, 5'h00, 1'b1, 1'b1}, // R11
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R9
    '{1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC0, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R10 setup
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC0, 2'b10, 1'b0, 5'h00, 1'b0, 1'b0}, // R10
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC0, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R9
    '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}, // R2
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 2'b01, 1'b0, 5'h1F, 1'b1, 1'b0}, // R7
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0}  // R9
  };

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sleep_req, irq_wake, nmi_wake, wdt_running, dma_busy;
  logic       cpu_clk_en, pin_oe, pin_hold;
  logic [4:0] mod_clk_en;
  logic [1:0] mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pwrdn_ctrl u_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .irq_wake(irq_wake),
    .nmi_wake(nmi_wake), .wdt_running(wdt_running), .dma_busy(dma_busy),
    .cpu_clk_en(cpu_clk_en), .mod_clk_en(mod_clk_en), .pin_oe(pin_oe),
    .pin_hold(pin_hold), .mode(mode));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_all(input string req, input logic [7:0] erd,
                           input logic [1:0] emode, input logic ecpu,
                           input logic [4:0] emod, input logic eoe,
                           input logic ehold);
    logic [17:0] act, exp;
    act = {rd_data, mode, cpu_clk_en, mod_clk_en, pin_oe, pin_hold};
    exp = {erd, emode, ecpu, emod, eoe, ehold};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual rd=%h mode=%b cpu=%b mod=%b oe=%b hold=%b expected rd=%h mode=%b cpu=%b mod=%b oe=%b hold=%b",
               req, rd_data, mode, cpu_clk_en, mod_clk_en, pin_oe, pin_hold,
               erd, emode, ecpu, emod, eoe, ehold);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 8'h00; sleep_req = 0; irq_wake = 0;
    nmi_wake = 0; wdt_running = 0; dma_busy = 0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check_all("R1 during reset", 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release", 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      wr_en = VECS[i].wr; wr_data = VECS[i].d; wdt_running = VECS[i].wdt;
      dma_busy = VECS[i].dma; sleep_req = VECS[i].slp;
      irq_wake = VECS[i].irq; nmi_wake = VECS[i].nmi;
      @(negedge clk);
      idle_inputs();
      check_all($sformatf("vector %0d (R2-R11 table)", i), VECS[i].erd,
                VECS[i].emode, VECS[i].ecpu, VECS[i].emod, VECS[i].eoe,
                VECS[i].ehold);
    end

    // R4: SBY already set stays set while the watchdog runs
    wr_en = 1; wr_data = 8'h80; @(negedge clk);
    wr_en = 1; wr_data = 8'h82; wdt_running = 1; @(negedge clk);
    idle_inputs();
    check_all("R4 held set", 8'h82, 2'b00, 1'b1, 5'h1D, 1'b1, 1'b0);

    // R12: enter standby with HIZ=1 then reset asynchronously mid-cycle
    wr_en = 1; wr_data = 8'hDF; @(negedge clk);
    idle_inputs(); sleep_req = 1; @(negedge clk);
    idle_inputs();
    check_all("R8 standby before reset", 8'hDF, 2'b10, 1'b0, 5'h00, 1'b0, 1'b0);
    #2 rst_n = 1'b0;
    #1;
    check_all("R12 async reset", 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12 after release", 8'h00, 2'b00, 1'b1, 5'h1F, 1'b1, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule